// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a three-wire serial audio stream into parallel samples. The three wires are a bit clock, a frame clock and a data line. All three are oversampled by a faster system clock, synchronised, and examined on each active bit-clock edge. Static configuration inputs select the framing:

- **Right-justified:** the word ends at the frame-clock change.
- **Left-justified:** the word starts on the change.
- **I2S:** the word starts one bit after the change.
- **DSP:** a frame-clock pulse starts a frame, and the left and right words follow back to back.

Further configuration inputs set the word length, which bit-clock edge samples the line, and the frame-clock sense. In DSP format the frame-clock sense input selects between the two DSP sub-modes instead.

Each recovered word is placed MSB-first in a 32-bit output and zero-filled below the word. It appears for one system-clock cycle with a strobe and a channel tag. The block never presents a right word that is not preceded by its left word. Configuration is expected to change only while the block is held in reset.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is asserted, `rx_valid` is 0, `rx_right` is 0 and `rx_data` is all zeros.
- R2: With `bclk_inv` = 0, the frame clock and data are sampled on rising bit-clock edges. With `bclk_inv` = 1, they are sampled on falling edges.
- R3: `fmt` selects the framing: 2'b00 right-justified, 2'b01 left-justified, 2'b10 I2S, 2'b11 DSP.
- R4: `wlen` selects the word length N: 2'b00 = 16, 2'b01 = 20, 2'b10 = 24, 2'b11 = 32 bits.
- R5: In I2S format, the left channel occupies the time the effective frame clock is low. The MSB is sampled on the first active edge after the edge on which the frame-clock change is seen.
- R6: In left-justified format, the left channel occupies the time the effective frame clock is high. The MSB is sampled on the same active edge on which the frame-clock change is first seen.
- R7: In right-justified format, the left channel occupies the time the effective frame clock is high. The last N bits sampled before the frame-clock change form the word of the channel that just ended.
- R8: In the three non-DSP formats, `lr_inv` = 1 inverts the frame clock before it is interpreted.
- R9: In DSP format, a low-to-high frame clock marks a frame start. With `lr_inv` = 1 the left MSB is sampled on that same edge. With `lr_inv` = 0 it is sampled one edge later. The right word's N bits follow the left word's N bits with no gap.
- R10: Each word is MSB-aligned at bit 31 of `rx_data`. Bits below the word are zero, and line bits outside the word are ignored.
- R11: `rx_valid` pulses for exactly one clock cycle per word. `rx_right` is 0 for a left word and 1 for a right word.
- R12: No word is produced before the first frame-clock change after reset. A right word is produced only if a left word has been produced since the previous right word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_inv | input | 1 | Sampling edge select: 0 rising, 1 falling |
| lr_inv | input | 1 | Frame-clock invert (non-DSP) or DSP sub-mode select |
| fmt | input | 2 | Framing format select |
| wlen | input | 2 | Word length select |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Serial frame clock |
| sdata | input | 1 | Serial data |
| rx_valid | output | 1 | One-cycle strobe per received word |
| rx_right | output | 1 | Channel tag of the presented word |
| rx_data | output | 32 | Received word, MSB-aligned and zero-filled |

## Verification
The bench fills every bit outside a word with ones. A receiver that shifts by the wrong amount or leaks slot padding then shows set bits below or above the expected word. Words are sent at all four lengths, with both sampling edges and both frame-clock senses. This catches an off-by-one MSB position in I2S, left-justified and DSP sub-mode A, which appears as a word shifted by one bit. It also catches a right-justified receiver that includes the bit on the transition edge. A stream that opens in the right channel checks that an orphan right word is dropped rather than presented ahead of its left partner.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;

  localparam int SLOT_W = 32;
  localparam int CNT_W  = $clog2(SLOT_W + 1);

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // One sampled serial bit, valid when stb is high
  typedef struct packed {
    logic stb;
    logic dat;
    logic lr;
  } bit_ev_t;

  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] wl);
    case (wl)
      2'b00:   return CNT_W'(16);
      2'b01:   return CNT_W'(20);
      2'b10:   return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/aud_ser_rx_sync.sv
module aud_ser_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/aud_ser_rx_edge.sv
module aud_ser_rx_edge
  import aud_ser_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bclk_s,
  input  logic    dat_s,
  input  logic    lr_s,
  input  logic    bclk_inv,
  output bit_ev_t ev
);

  logic bclk_d, bclk_d_n;

  always_comb begin
    bclk_d_n = bclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_d_n;
  end

  always_comb begin
    ev.stb = bclk_inv ? (bclk_d & ~bclk_s) : (~bclk_d & bclk_s);
    ev.dat = dat_s;
    ev.lr  = lr_s;
  end

endmodule

// File: rtl/aud_ser_rx_framer.sv
module aud_ser_rx_framer
  import aud_ser_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bit_ev_t           ev,
  input  fmt_e              fmt,
  input  logic [1:0]        wlen,
  input  logic              lr_inv,
  output logic              emit,
  output logic              emit_right,
  output logic [SLOT_W-1:0] emit_word
);

  logic [SLOT_W-1:0] shreg, shreg_n;
  logic              lr_q, lr_q_n;
  logic              seen, seen_n;
  logic              pend, pend_n;
  logic              pend_ch, pend_ch_n;
  logic              active, active_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              ch, ch_n;
  logic              armed, armed_n;
  logic              lflag, lflag_n;

  logic              is_dsp, lr_e, trans, new_ch, delay1, start, start_ch;
  logic [CNT_W-1:0]  nbits;
  logic [SLOT_W-1:0] hist;

  always_comb begin
    nbits    = word_bits(wlen);
    is_dsp   = (fmt == FMT_DSP);
    lr_e     = is_dsp ? ev.lr : (ev.lr ^ lr_inv);
    trans    = seen & (is_dsp ? (lr_e & ~lr_q) : (lr_e ^ lr_q));
    new_ch   = is_dsp ? 1'b0 : ((fmt == FMT_I2S) ? lr_e : ~lr_e);
    delay1   = (fmt == FMT_I2S) | (is_dsp & ~lr_inv);
    hist     = {shreg[SLOT_W-2:0], ev.dat};
    start_ch = pend ? pend_ch : new_ch;
    start    = (trans & ~delay1) | pend;

    shreg_n    = shreg;
    lr_q_n     = lr_q;
    seen_n     = seen;
    pend_n     = pend;
    pend_ch_n  = pend_ch;
    active_n   = active;
    cnt_n      = cnt;
    ch_n       = ch;
    armed_n    = armed;
    lflag_n    = lflag;
    emit       = 1'b0;
    emit_right = 1'b0;
    emit_word  = '0;

    if (ev.stb) begin
      shreg_n = hist;
      lr_q_n  = lr_e;
      seen_n  = 1'b1;
      pend_n  = 1'b0;
      if (fmt == FMT_RJ) begin
        if (trans) begin
          armed_n = 1'b1;
          if (armed && (lr_q || lflag)) begin
            emit       = 1'b1;
            emit_right = ~lr_q;
            emit_word  = shreg;
          end
        end
      end else begin
        if (trans && delay1) begin
          pend_n    = 1'b1;
          pend_ch_n = new_ch;
          active_n  = 1'b0;
        end else if (start) begin
          if (start_ch && !lflag) begin
            active_n = 1'b0;
          end else begin
            active_n = 1'b1;
            cnt_n    = CNT_W'(1);
            ch_n     = start_ch;
          end
        end else if (active) begin
          cnt_n = CNT_W'(cnt + 1'b1);
        end
        if (active_n && (cnt_n == nbits)) begin
          emit       = 1'b1;
          emit_right = ch_n;
          emit_word  = hist;
          if (is_dsp && !ch_n) begin
            ch_n  = 1'b1;
            cnt_n = '0;
          end else begin
            active_n = 1'b0;
          end
        end
      end
      if (emit) lflag_n = ~emit_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      lr_q    <= 1'b0;
      seen    <= 1'b0;
      pend    <= 1'b0;
      pend_ch <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      ch      <= 1'b0;
      armed   <= 1'b0;
      lflag   <= 1'b0;
    end else begin
      shreg   <= shreg_n;
      lr_q    <= lr_q_n;
      seen    <= seen_n;
      pend    <= pend_n;
      pend_ch <= pend_ch_n;
      active  <= active_n;
      cnt     <= cnt_n;
      ch      <= ch_n;
      armed   <= armed_n;
      lflag   <= lflag_n;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= word_bits(wlen));

  // R12
  first_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> seen);

endmodule

// File: rtl/aud_ser_rx_out.sv
module aud_ser_rx_out
  import aud_ser_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              emit_right,
  input  logic [SLOT_W-1:0] emit_word,
  input  logic [1:0]        wlen,
  output logic              rx_valid,
  output logic              rx_right,
  output logic [SLOT_W-1:0] rx_data
);

  logic              valid_n, right_n;
  logic [SLOT_W-1:0] data_n;
  logic [CNT_W-1:0]  nbits;

  always_comb begin
    nbits   = word_bits(wlen);
    valid_n = emit;
    right_n = emit ? emit_right : rx_right;
    data_n  = emit ? (emit_word << (SLOT_W - int'(nbits))) : rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_right <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= valid_n;
      rx_right <= right_n;
      rx_data  <= data_n;
    end
  end

  // Checker-only record of the last presented channel
  logic last_left;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_left <= 1'b0;
    else if (rx_valid) last_left <= ~rx_right;
  end

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (!rx_valid && rx_data == '0));

  // R11
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && wlen == 2'b00) |-> (rx_data[15:0] == 16'h0));

  // R12
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_right) |-> last_left);

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_ser_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_inv,
  input  logic        lr_inv,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdata,
  output logic        rx_valid,
  output logic        rx_right,
  output logic [31:0] rx_data
);

  logic [1:0] rst_ff;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_i = rst_ff[1];

  logic [2:0] line_s;
  bit_ev_t    ev;
  logic       emit, emit_right;
  logic [SLOT_W-1:0] emit_word;

  aud_ser_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   ({bclk, lrclk, sdata}),
    .dout  (line_s)
  );

  aud_ser_rx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .bclk_s   (line_s[2]),
    .dat_s    (line_s[0]),
    .lr_s     (line_s[1]),
    .bclk_inv (bclk_inv),
    .ev       (ev)
  );

  aud_ser_rx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .ev         (ev),
    .fmt        (fmt_e'(fmt)),
    .wlen       (wlen),
    .lr_inv     (lr_inv),
    .emit       (emit),
    .emit_right (emit_right),
    .emit_word  (emit_word)
  );

  aud_ser_rx_out u_out (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .emit       (emit),
    .emit_right (emit_right),
    .emit_word  (emit_word),
    .wlen       (wlen),
    .rx_valid   (rx_valid),
    .rx_right   (rx_right),
    .rx_data    (rx_data)
  );

endmodule

// File: tb/aud_ser_rx_tb.sv
`timescale 1ns/1ps
module aud_ser_rx_tb;

  localparam int H  = 3;   // system clocks per bit-clock half period
  localparam int SL = 36;  // bit slots per channel in the non-DSP formats

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_inv_c, lr_inv_c;
  logic [1:0]  fmt_c, wl_c;
  logic        bclk, lrclk, sdata;
  logic        rx_valid, rx_right;
  logic [31:0] rx_data;

  int    nchk = 0;
  int    nfail = 0;
  bit    done = 0;
  bit    prev_valid = 0;
  string cur_req = "R1";
  logic [32:0] expq[$];

  always #2.5 clk = ~clk;

  aud_ser_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_inv(bclk_inv_c), .lr_inv(lr_inv_c),
    .fmt(fmt_c), .wlen(wl_c), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .rx_valid(rx_valid), .rx_right(rx_right), .rx_data(rx_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int nbits(input logic [1:0] wl);
    return (wl == 2'b11) ? 32 : 16 + 4 * int'(wl);
  endfunction

  // Reference: every presented word is compared with the next expected one
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      nchk++;
      if (prev_valid) begin
        nfail++;
        $display("FAIL R11: strobe held, got 2 cycles expected 1");
      end
      nchk++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL %s: got word %0d_%h expected none", cur_req, rx_right, rx_data);
      end else begin
        logic [32:0] e;
        e = expq.pop_front();
        if ({rx_right, rx_data} !== e) begin
          nfail++;
          $display("FAIL %s: got %0d_%h expected %0d_%h", cur_req, rx_right, rx_data, e[32], e[31:0]);
        end
      end
    end
    prev_valid = rst_n && rx_valid;
  end

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl, input logic bi,
                          input logic li, input logic lr0);
    rst_n = 1'b0;
    fmt_c = f; wl_c = wl; bclk_inv_c = bi; lr_inv_c = li;
    bclk = ~bi; lrclk = lr0; sdata = 1'b0;
    expq.delete();
    tick(3);
    nchk++;  // R1
    if (rx_valid !== 1'b0 || rx_right !== 1'b0 || rx_data !== 32'h0) begin
      nfail++;
      $display("FAIL R1: got %b %b %h expected 0 0 00000000", rx_valid, rx_right, rx_data);
    end
    rst_n = 1'b1;
    tick(6);
  endtask

  task automatic send_bit(input logic d, input logic lr);
    bclk = bclk_inv_c; sdata = d; lrclk = lr;
    tick(H);
    bclk = ~bclk_inv_c;
    tick(H);
  endtask

  // Frame-clock pin level for channel c (0 left, 1 right) in non-DSP formats
  function automatic logic lr_pin(input int c);
    logic eff;
    eff = (fmt_c == 2'b10) ? logic'(c) : ~logic'(c);
    return eff ^ lr_inv_c;
  endfunction

  function automatic logic [31:0] rnd_word(input int n);
    logic [31:0] m;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    return $urandom() & m;
  endfunction

  task automatic send_slot(input int c, input logic [31:0] w, input int n);
    for (int k = 0; k < SL; k++) begin
      logic b;
      b = 1'b1;
      case (fmt_c)
        2'b01: if (k < n) b = w[n-1-k];
        2'b10: if (k >= 1 && k <= n) b = w[n-k];
        default: if (k >= SL - n) b = w[SL-1-k];
      endcase
      send_bit(b, lr_pin(c));
    end
  endtask

  task automatic end_test(input string req);
    tick(40);
    nchk++;
    if (expq.size() != 0) begin
      nfail++;
      $display("FAIL %s: got %0d words missing expected 0", req, expq.size());
    end
  endtask

  task automatic run_std(input logic [1:0] f, input logic [1:0] wl, input logic bi,
                         input logic li, input int nfr, input bit lead_right, input string req);
    int n;
    n = nbits(wl);
    cur_req = req;
    fmt_c = f; lr_inv_c = li;
    do_reset(f, wl, bi, li, lr_pin(lead_right ? 0 : 1));
    for (int i = 0; i < 4; i++) send_bit(1'b1, lr_pin(lead_right ? 0 : 1));
    if (lead_right) send_slot(1, rnd_word(n), n);  // orphan right word: dropped
    for (int i = 0; i < nfr; i++) begin
      logic [31:0] wl_w, wr_w;
      wl_w = rnd_word(n);
      wr_w = rnd_word(n);
      expq.push_back({1'b0, wl_w << (32 - n)});
      expq.push_back({1'b1, wr_w << (32 - n)});
      send_slot(0, wl_w, n);
      send_slot(1, wr_w, n);
    end
    for (int i = 0; i < 4; i++) send_bit(1'b1, lr_pin(0));
    end_test(req);
  endtask

  task automatic run_dsp(input logic [1:0] wl, input logic bi, input logic mode_b,
                         input int nfr, input string req);
    int n;
    n = nbits(wl);
    cur_req = req;
    do_reset(2'b11, wl, bi, mode_b, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    for (int i = 0; i < nfr; i++) begin
      logic [31:0] wl_w, wr_w;
      wl_w = rnd_word(n);
      wr_w = rnd_word(n);
      expq.push_back({1'b0, wl_w << (32 - n)});
      expq.push_back({1'b1, wr_w << (32 - n)});
      if (!mode_b) send_bit(1'b1, 1'b1);
      for (int k = 0; k < n; k++) send_bit(wl_w[n-1-k], (mode_b && k == 0) ? 1'b1 : 1'b0);
      for (int k = 0; k < n; k++) send_bit(wr_w[n-1-k], 1'b0);
      for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0);
    end
    end_test(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    // R5 R3: I2S, 24-bit, default polarities
    run_std(2'b10, 2'b10, 1'b0, 1'b0, 3, 1'b0, "R5");
    // R2 R4: I2S, 16-bit, falling-edge sampling
    run_std(2'b10, 2'b00, 1'b1, 1'b0, 3, 1'b0, "R2");
    // R6: left-justified, 20-bit
    run_std(2'b01, 2'b01, 1'b0, 1'b0, 3, 1'b0, "R6");
    // R8 R10: left-justified, 32-bit, inverted frame clock
    run_std(2'b01, 2'b11, 1'b0, 1'b1, 3, 1'b0, "R8");
    // R7: right-justified, 24-bit
    run_std(2'b00, 2'b10, 1'b0, 1'b0, 3, 1'b0, "R7");
    // R7 R8 R2: right-justified, 16-bit, both clocks inverted
    run_std(2'b00, 2'b00, 1'b1, 1'b1, 3, 1'b0, "R7");
    // R9: DSP sub-mode A, 16-bit
    run_dsp(2'b00, 1'b0, 1'b0, 3, "R9");
    // R9 R2: DSP sub-mode B, 24-bit, falling-edge sampling
    run_dsp(2'b10, 1'b1, 1'b1, 3, "R9");
    // R9 R4: DSP sub-mode B, 32-bit
    run_dsp(2'b11, 1'b0, 1'b1, 2, "R9");
    // R12: streams that open in the right channel
    run_std(2'b01, 2'b10, 1'b0, 1'b0, 2, 1'b1, "R12");
    run_std(2'b10, 2'b01, 1'b0, 1'b0, 2, 1'b1, "R12");
    run_std(2'b00, 2'b00, 1'b0, 1'b0, 2, 1'b1, "R12");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule